// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 64 interrupt request lines and drives a single interrupt line toward a processor. Each source has a mask bit, a sensitivity mode (edge or level) and a priority level. Software controls the block through a small 32-bit register bus. Mask bits are changed with separate set and clear registers for each 32-source half, so no read-modify-write is needed. The winning source is found by reading a vector register, and handling is closed by writing an end-of-interrupt register.

Reading the vector register with a valid winner records that winner's priority level as in service. Until the matching end-of-interrupt write, sources at that level or below cannot raise the line. A source at a strictly higher level can still preempt, which gives nested handling. When no source qualifies, the vector read returns the out-of-range code 64 and nothing is recorded.

A two-state machine drives the output line. In `ST_QUIET` the line is low. In `ST_ASSERT` the line is high. The machine takes the **raise** transition (`ST_QUIET` to `ST_ASSERT`) when the global enable is on and an eligible source exists. It takes the **drop** transition (`ST_ASSERT` to `ST_QUIET`) when either condition goes away or a soft reset is written. The line therefore follows eligibility one clock later.

Top module: `vic_top`

## Requirements
- R1: After `rst_n` is deasserted, every mask bit, configuration field, latched edge, in-service level and the global enable are zero, `irq_o` is low, and a vector read returns 64.
- R2: A write to offset 0x00 (sources 0–31) or 0x04 (sources 32–63) sets each mask bit whose data bit is 1 and leaves bits written as 0 unchanged. Reading the same offset returns the mask half.
- R3: A write to offset 0x08 (sources 0–31) or 0x0C (sources 32–63) clears each mask bit whose data bit is 1. A masked source never wins and never raises `irq_o`.
- R4: The configuration word of source n is at offset 0x200 + 8·n. Bit 8 selects edge mode when 1 and level mode when 0. Bits [2:0] hold the priority level. The word reads back as written in those fields and as zero elsewhere.
- R5: A level-mode source is pending exactly while its input is high.
- R6: An edge-mode source latches pending on a rising input and stays pending after the input falls. Only a write to its configuration word, or a soft reset, clears the latch.
- R7: A read of offset 0x10 returns the number of the eligible source with the highest priority level. On a tie, the lowest source number wins.
- R8: When no enabled, pending source outranks the in-service level, a vector read returns 64 and changes no state.
- R9: A vector read with a valid winner marks the winner's level in service. Sources at that level or lower are then not eligible, while a strictly higher level stays eligible and nests.
- R10: Any write to offset 0x14 retires the highest in-service level.
- R11: A write to offset 0x1C sets the global enable from data bit 0, and the enable reads back there. `irq_o` is high only in `ST_ASSERT`, which is entered one clock after the global enable is on and an eligible source exists.
- R12: A write to offset 0x18 with data bit 0 set clears every mask bit, configuration word, latched edge, in-service level and the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for one cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_src | input | 64 | Interrupt request inputs, synchronous to `clk` |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with its defaults: 64 sources and a 3-bit priority field. This places real sources in the upper mask half, including source 63 at the top of the range. It also gives eight priority levels, which is enough for ties, a masked top source and two-deep nesting within one run. Giving source n the level (3·n) mod 8 produces all of these orderings from a single level setup, and the walked table mixes sources from both halves.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_ASSERT = 1'b1
    } vic_state_e;

    localparam logic [4:0] OFS_SET_LO  = 5'h00;
    localparam logic [4:0] OFS_SET_HI  = 5'h04;
    localparam logic [4:0] OFS_CLR_LO  = 5'h08;
    localparam logic [4:0] OFS_CLR_HI  = 5'h0C;
    localparam logic [4:0] OFS_VECTOR  = 5'h10;
    localparam logic [4:0] OFS_DONE    = 5'h14;
    localparam logic [4:0] OFS_WIPE    = 5'h18;
    localparam logic [4:0] OFS_GLOBAL  = 5'h1C;

    localparam int CFG_EDGE_BIT = 8;

endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wipe,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] cfg_touch,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic prev_q;
        logic latch_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                prev_q <= src_in[g];
                if (wipe || cfg_touch[g])
                    latch_q <= 1'b0;
                else if (src_in[g] && !prev_q)
                    latch_q <= 1'b1;
            end
        end

        assign pend[g] = edge_mode[g] ? latch_q : src_in[g];
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter  int NUM_SRC = 64,
    parameter  int PRIO_W  = 3,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic                           floor_on,
    input  logic [PRIO_W-1:0]              floor_lvl,
    output logic                           win_valid,
    output logic [SRC_W-1:0]               win_id,
    output logic [PRIO_W-1:0]              win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!floor_on || prio[i] > floor_lvl) &&
                (!win_valid || prio[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_id    = SRC_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/vic_inservice.sv
module vic_inservice #(
    parameter  int PRIO_W = 3,
    localparam int NLVL   = 1 << PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              pop,
    output logic              active,
    output logic [PRIO_W-1:0] top_lvl
);
    logic [NLVL-1:0] isr_q;
    logic [NLVL-1:0] isr_d;

    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NLVL; l++)
            if (isr_q[l]) top_lvl = PRIO_W'(l);
    end

    assign active = |isr_q;

    always_comb begin
        isr_d = isr_q;
        if (pop && active) isr_d[top_lvl] = 1'b0;
        if (push)          isr_d[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    isr_q <= '0;
        else if (wipe) isr_q <= '0;
        else           isr_q <= isr_d;
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter  int NUM_SRC = 64,
    parameter  int PRIO_W  = 3,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int ADDR_W  = SRC_W + 4,
    localparam int HALF    = NUM_SRC / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_o
);
    logic [NUM_SRC-1:0]             en_q;
    logic                           gen_q;
    logic [NUM_SRC-1:0]             cfg_edge_q;
    logic [NUM_SRC-1:0][PRIO_W-1:0] cfg_prio_q;
    logic [NUM_SRC-1:0]             cfg_touch;
    logic [NUM_SRC-1:0]             pend;
    logic                           win_valid;
    logic [SRC_W-1:0]               win_id;
    logic [PRIO_W-1:0]              win_prio;
    logic                           floor_on;
    logic [PRIO_W-1:0]              floor_lvl;
    vic_state_e                     state_q, state_d;

    // Address decode: the top bit picks the configuration window.
    wire              is_cfg  = bus_addr[ADDR_W-1];
    wire [SRC_W-1:0]  cfg_idx = bus_addr[SRC_W+2:3];
    wire [4:0]        ofs     = bus_addr[4:0];
    wire              reg_win = !is_cfg && (bus_addr[ADDR_W-2:5] == '0);
    wire              wr_reg  = bus_sel && bus_wr && reg_win;
    wire              rd_reg  = bus_sel && !bus_wr && reg_win;
    wire              wipe    = wr_reg && (ofs == OFS_WIPE) && bus_wdata[0];
    wire              vec_rd  = rd_reg && (ofs == OFS_VECTOR);
    wire              eoi_wr  = wr_reg && (ofs == OFS_DONE);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            cfg_touch[i] = bus_sel && bus_wr && is_cfg && (cfg_idx == SRC_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            gen_q      <= 1'b0;
            cfg_edge_q <= '0;
            cfg_prio_q <= '0;
        end else if (wipe) begin
            en_q       <= '0;
            gen_q      <= 1'b0;
            cfg_edge_q <= '0;
            cfg_prio_q <= '0;
        end else begin
            if (wr_reg) begin
                unique case (ofs)
                    OFS_SET_LO: en_q[HALF-1:0]       <= en_q[HALF-1:0] | bus_wdata[HALF-1:0];
                    OFS_SET_HI: en_q[NUM_SRC-1:HALF] <= en_q[NUM_SRC-1:HALF] | bus_wdata[HALF-1:0];
                    OFS_CLR_LO: en_q[HALF-1:0]       <= en_q[HALF-1:0] & ~bus_wdata[HALF-1:0];
                    OFS_CLR_HI: en_q[NUM_SRC-1:HALF] <= en_q[NUM_SRC-1:HALF] & ~bus_wdata[HALF-1:0];
                    OFS_GLOBAL: gen_q                <= bus_wdata[0];
                    default: ;
                endcase
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (cfg_touch[i]) begin
                    cfg_edge_q[i] <= bus_wdata[CFG_EDGE_BIT];
                    cfg_prio_q[i] <= bus_wdata[PRIO_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= '0;
            if (is_cfg) begin
                bus_rdata[CFG_EDGE_BIT] <= cfg_edge_q[cfg_idx];
                bus_rdata[PRIO_W-1:0]   <= cfg_prio_q[cfg_idx];
            end else if (rd_reg) begin
                unique case (ofs)
                    OFS_SET_LO: bus_rdata <= 32'(en_q[HALF-1:0]);
                    OFS_SET_HI: bus_rdata <= 32'(en_q[NUM_SRC-1:HALF]);
                    OFS_GLOBAL: bus_rdata <= 32'(gen_q);
                    OFS_VECTOR: bus_rdata <= win_valid ? 32'(win_id) : 32'(NUM_SRC);
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

    vic_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .src_in    (irq_src),
        .edge_mode (cfg_edge_q),
        .cfg_touch (cfg_touch),
        .pend      (pend)
    );

    vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .req       (pend & en_q),
        .prio      (cfg_prio_q),
        .floor_on  (floor_on),
        .floor_lvl (floor_lvl),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    vic_inservice #(.PRIO_W(PRIO_W)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (wipe),
        .push     (vec_rd && win_valid),
        .push_lvl (win_prio),
        .pop      (eoi_wr),
        .active   (floor_on),
        .top_lvl  (floor_lvl)
    );

    // Next-state logic: raise / drop.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (!wipe && gen_q && win_valid)  state_d = ST_ASSERT;
            ST_ASSERT: if (wipe || !gen_q || !win_valid) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == ST_ASSERT);
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter  int NUM_SRC = 64,
    parameter  int PRIO_W  = 3,
    localparam int ADDR_W  = $clog2(NUM_SRC) + 4,
    localparam int HALF    = NUM_SRC / 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] en_q,
    input logic               gen_q,
    input logic               win_valid,
    input logic               floor_on,
    input logic [PRIO_W-1:0]  floor_lvl
);
    wire wr_at  = bus_sel && bus_wr;
    wire rd_vec = bus_sel && !bus_wr && (bus_addr == ADDR_W'(16));

    AST_SET_LO_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(0) |=>
        en_q[HALF-1:0] == ($past(en_q[HALF-1:0]) | $past(bus_wdata[HALF-1:0]))); // R2

    AST_CLR_LO_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(8) |=>
        en_q[HALF-1:0] == ($past(en_q[HALF-1:0]) & ~$past(bus_wdata[HALF-1:0]))); // R3

    AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vec && !win_valid |=> bus_rdata == 32'(NUM_SRC)); // R8

    AST_VEC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vec && win_valid |=> floor_on); // R9

    AST_EOI_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(20) && floor_on |=>
        (!floor_on || floor_lvl < $past(floor_lvl))); // R10

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gen_q)); // R11

    AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(24) && bus_wdata[0] |=>
        (en_q == '0 && !gen_q && !floor_on)); // R12
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .gen_q     (gen_q),
    .win_valid (win_valid),
    .floor_on  (floor_on),
    .floor_lvl (floor_lvl)
);

// File: tb/vic_top_tb.sv
`timescale 1ns/1ps
module vic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_o;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    vic_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_o(irq_o)
    );

    // {source pattern, expected vector, expected irq}; source n has level (3n) mod 8
    localparam logic [71:0] VEC_TAB [8] = '{
        {64'h0000_0000_0000_0000, 7'd64, 1'b0},
        {64'h0000_0000_0000_0001, 7'd0,  1'b1},
        {64'h0000_0000_0000_0003, 7'd1,  1'b1},
        {64'h0000_0000_0000_0006, 7'd2,  1'b1},
        {64'h0000_0000_0000_2020, 7'd5,  1'b1},
        {64'h8000_0100_0000_0000, 7'd63, 1'b1},
        {64'h0000_0020_0000_0004, 7'd37, 1'b1},
        {64'h0000_0000_0001_0100, 7'd8,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        rd(10'h000, d); chk("R1 mask lo", d, 0);
        rd(10'h004, d); chk("R1 mask hi", d, 0);
        rd(10'h01C, d); chk("R1 global", d, 0);
        rd(10'h10, d);  chk("R1 vector", d, 64);

        // setup: all enabled, level mode, level (3n) mod 8
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h004, 32'hFFFF_FFFF);
        for (int n = 0; n < 64; n++) wr(10'h200 + 10'(n * 8), 32'((n * 3) % 8));
        rd(10'h200 + 10'(6 * 8), d); chk("R4 readback", d, 32'h2);
        wr(10'h01C, 32'h1);

        // R5 R7 R8 walked vectors
        for (int k = 0; k < 8; k++) begin
            irq_src = VEC_TAB[k][71:8];
            settle();
            chk("R5 R11 irq", 32'(irq_o), 32'(VEC_TAB[k][0]));
            rd(10'h010, d); chk("R7 R8 vector", d, 32'(VEC_TAB[k][7:1]));
            wr(10'h014, 32'h0);
            irq_src = '0;
            settle();
        end

        // R6 edge latch on source 10, level 4
        wr(10'h200 + 10'd80, 32'h104);
        rd(10'h200 + 10'd80, d); chk("R4 edge readback", d, 32'h104);
        @(negedge clk) irq_src[10] = 1'b1;
        @(negedge clk) irq_src[10] = 1'b0;
        settle();
        chk("R6 latched irq", 32'(irq_o), 1);
        rd(10'h010, d); chk("R6 vector", d, 10);
        wr(10'h014, 32'h0);
        settle();
        chk("R6 still latched", 32'(irq_o), 1);
        wr(10'h200 + 10'd80, 32'h104);
        settle();
        chk("R6 cleared by cfg", 32'(irq_o), 0);
        rd(10'h010, d); chk("R6 vector after clear", d, 64);

        // R9 R10 in-service and nesting
        irq_src[4] = 1'b1; settle();
        rd(10'h010, d); chk("R9 first", d, 4);
        settle(); chk("R9 same level held", 32'(irq_o), 0);
        irq_src[0] = 1'b1; settle();
        chk("R9 lower held", 32'(irq_o), 0);
        rd(10'h010, d); chk("R8 held vector", d, 64);
        irq_src[5] = 1'b1; settle();
        chk("R9 higher nests", 32'(irq_o), 1);
        rd(10'h010, d); chk("R9 nested vector", d, 5);
        wr(10'h014, 32'h0); settle();
        chk("R10 pop top", 32'(irq_o), 1);
        irq_src[5] = 1'b0; settle();
        chk("R10 outer still held", 32'(irq_o), 0);
        wr(10'h014, 32'h0); settle();
        chk("R10 outer retired", 32'(irq_o), 1);
        rd(10'h010, d); chk("R10 vector", d, 4);
        wr(10'h014, 32'h0);
        irq_src = '0; settle();

        // R2 R3 masking
        wr(10'h008, 32'h2);
        rd(10'h000, d); chk("R3 clear lo", d, 32'hFFFF_FFFD);
        wr(10'h004, 32'h0);
        rd(10'h004, d); chk("R2 zero no effect", d, 32'hFFFF_FFFF);
        wr(10'h00C, 32'h8000_0000);
        rd(10'h004, d); chk("R3 clear hi", d, 32'h7FFF_FFFF);
        irq_src[63] = 1'b1; settle();
        chk("R3 masked irq", 32'(irq_o), 0);
        rd(10'h010, d); chk("R3 masked vector", d, 64);
        irq_src = '0;
        wr(10'h004, 32'h8000_0000);
        rd(10'h004, d); chk("R2 set hi", d, 32'hFFFF_FFFF);

        // R11 global enable
        wr(10'h01C, 32'h0);
        irq_src[2] = 1'b1; settle();
        chk("R11 gated", 32'(irq_o), 0);
        rd(10'h01C, d); chk("R11 readback", d, 0);
        wr(10'h01C, 32'h1); settle();
        chk("R11 enabled", 32'(irq_o), 1);

        // R12 soft reset
        wr(10'h018, 32'h1); settle();
        chk("R12 irq", 32'(irq_o), 0);
        rd(10'h000, d); chk("R12 mask lo", d, 0);
        rd(10'h01C, d); chk("R12 global", d, 0);
        rd(10'h200 + 10'd80, d); chk("R12 cfg", d, 0);
        irq_src = '0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule